// File: doc/BRIEF.md
# Burst SRAM address sequencer

This block is the address half of a synchronous burst static memory with two start strobes. On every rising clock edge it samples a processor-side start strobe, a controller-side start strobe, a burst step input, three chip enables and an order-select pin. All of these except the order select are active low. When a cycle starts, the external address is loaded into an internal register. Each later step then produces the next beat address by rewriting only the two lowest address bits.

The two strobes are gated differently. A processor-side start needs every chip enable active, and enable 0 can suppress it entirely. A controller-side start ignores enable 0 and takes effect whenever the processor side is not taking the edge. A start seen while the other enables are inactive deselects the block. The burst order is captured at the start edge: interleaved (offset XOR beat) when the pin is HIGH, linear (offset plus beat, modulo 4) when it is LOW. A parameter can tie the order to interleaved, which models an unconnected pin.

Top module: `burst_addr_seq`

## Requirements
- R1: While rst_n is LOW at a clock edge, busy becomes 0 and cur_addr becomes 0 after that edge.
- R2: When proc_strb_n is LOW and en_n is 3'b000, the edge loads ext_addr into cur_addr and sets busy, whatever the values of ctrl_strb_n and step_n.
- R3: When proc_strb_n is LOW, en_n[0] is LOW and en_n[1] or en_n[2] is HIGH, the edge clears busy and leaves cur_addr unchanged.
- R4: When proc_strb_n is LOW but en_n[0] is HIGH, the processor strobe has no effect. If ctrl_strb_n is also HIGH, busy and cur_addr hold, even with step_n LOW.
- R5: When ctrl_strb_n is LOW and the processor strobe is either HIGH or blocked by en_n[0], a controller start occurs. With en_n[1] and en_n[2] both LOW it loads ext_addr and sets busy, independent of en_n[0]. Otherwise it clears busy and holds cur_addr.
- R6: On a start edge step_n is ignored, so the first beat is exactly ext_addr.
- R7: The beat advances only when busy is 1, step_n is LOW, and proc_strb_n and ctrl_strb_n are both HIGH. Otherwise, with no start, cur_addr is unchanged.
- R8: With order_il HIGH at the start edge, beat k has cur_addr[1:0] = start[1:0] XOR k. The order stays fixed for that burst even if order_il later changes.
- R9: With order_il LOW at the start edge, beat k has cur_addr[1:0] = (start[1:0] + k) mod 4.
- R10: After four steps the low bits return to the start offset. cur_addr[AW-1:2] never changes during a burst.
- R11: With step_n HIGH and both strobes HIGH, busy and cur_addr hold.
- R12: With parameter ORDER_FIXED = 1, bursts are always interleaved regardless of order_il.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| proc_strb_n | input | 1 | Processor-side start strobe, active low |
| ctrl_strb_n | input | 1 | Controller-side start strobe, active low |
| step_n | input | 1 | Burst step request, active low |
| en_n | input | 3 | Chip enables, active low; bit 0 is the master enable |
| order_il | input | 1 | Order select: 1 interleaved, 0 linear |
| ext_addr | input | AW | External address loaded at a start |
| cur_addr | output | AW | Current internal beat address |
| busy | output | 1 | Cycle active flag |

## Verification
The bench builds the block with AW = 8, which keeps the vectors readable in hex while still leaving six upper bits whose stability across a burst can be seen. Instance u0 uses ORDER_FIXED = 0, so order_il steers both sequences. A second instance with ORDER_FIXED = 1 receives the same stimulus. With an odd start offset the interleaved and linear orders differ, so the two instances can be compared directly. The bench uses odd start offsets to separate the orders, and it covers competing strobes, deselects and enable-0 blocking.

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int AW          = 20,
  parameter bit ORDER_FIXED = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          proc_strb_n,
  input  logic          ctrl_strb_n,
  input  logic          step_n,
  input  logic [2:0]    en_n,
  input  logic          order_il,
  input  logic [AW-1:0] ext_addr,
  output logic [AW-1:0] cur_addr,
  output logic          busy
);
  logic [AW-1:0] base;
  logic [1:0]    beat;
  logic          il_q;

  wire proc_take = ~proc_strb_n & ~en_n[0];
  wire ctrl_take = ~proc_take & ~ctrl_strb_n;
  wire start     = proc_take | ctrl_take;
  wire sel_ok    = ~en_n[1] & ~en_n[2];
  wire advance   = busy & proc_strb_n & ctrl_strb_n & ~step_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base <= '0;
      beat <= 2'd0;
      il_q <= 1'b1;
      busy <= 1'b0;
    end else if (start) begin
      busy <= sel_ok;
      if (sel_ok) begin
        base <= ext_addr;
        beat <= 2'd0;
        il_q <= ORDER_FIXED | order_il;
      end
    end else if (advance) begin
      beat <= beat + 2'd1;
    end
  end

  wire [1:0] low = il_q ? (base[1:0] ^ beat) : (base[1:0] + beat);
  assign cur_addr = {base[AW-1:2], low};
endmodule

module burst_addr_seq_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          proc_strb_n,
  input logic          ctrl_strb_n,
  input logic          step_n,
  input logic [2:0]    en_n,
  input logic [AW-1:0] ext_addr,
  input logic [AW-1:0] cur_addr,
  input logic          busy
);
  // R2
  proc_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!proc_strb_n && en_n == 3'b000) |=> (busy && cur_addr == $past(ext_addr)));

  // R3
  proc_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!proc_strb_n && !en_n[0] && (en_n[1] || en_n[2])) |=> (!busy && $stable(cur_addr)));

  // R4
  master_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!proc_strb_n && en_n[0] && ctrl_strb_n) |=> ($stable(cur_addr) && $stable(busy)));

  // R5
  ctrl_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((proc_strb_n || en_n[0]) && !ctrl_strb_n && !en_n[1] && !en_n[2])
      |=> (busy && cur_addr == $past(ext_addr)));

  // R7
  step_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && proc_strb_n && ctrl_strb_n && !step_n) |=> (cur_addr[1:0] != $past(cur_addr[1:0])));

  // R10
  upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_strb_n && ctrl_strb_n) |=> (cur_addr[AW-1:2] == $past(cur_addr[AW-1:2])));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_strb_n && ctrl_strb_n && step_n) |=> ($stable(cur_addr) && $stable(busy)));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .proc_strb_n(proc_strb_n), .ctrl_strb_n(ctrl_strb_n),
  .step_n(step_n), .en_n(en_n), .ext_addr(ext_addr), .cur_addr(cur_addr), .busy(busy)
);

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int NV = 21;

  // {proc_n, ctrl_n, step_n, en_n[2:0], order_il, ext[7:0], exp_busy, exp_addr[7:0]}
  localparam logic [23:0] VEC [NV] = '{
    {1'b0,1'b1,1'b1,3'b000,1'b1,8'h35,1'b1,8'h35},
    {1'b1,1'b1,1'b0,3'b000,1'b1,8'h00,1'b1,8'h34},
    {1'b1,1'b1,1'b0,3'b000,1'b1,8'h00,1'b1,8'h37},
    {1'b1,1'b1,1'b0,3'b000,1'b1,8'h00,1'b1,8'h36},
    {1'b1,1'b1,1'b0,3'b000,1'b1,8'h00,1'b1,8'h35},
    {1'b1,1'b1,1'b1,3'b000,1'b1,8'h00,1'b1,8'h35},
    {1'b1,1'b0,1'b0,3'b000,1'b0,8'hC6,1'b1,8'hC6},
    {1'b1,1'b1,1'b0,3'b000,1'b0,8'h00,1'b1,8'hC7},
    {1'b1,1'b1,1'b0,3'b000,1'b0,8'h00,1'b1,8'hC4},
    {1'b1,1'b1,1'b0,3'b000,1'b0,8'h00,1'b1,8'hC5},
    {1'b1,1'b1,1'b0,3'b000,1'b0,8'h00,1'b1,8'hC6},
    {1'b0,1'b1,1'b0,3'b001,1'b0,8'h11,1'b1,8'hC6},
    {1'b0,1'b0,1'b1,3'b001,1'b0,8'h5A,1'b1,8'h5A},
    {1'b0,1'b1,1'b1,3'b010,1'b0,8'h99,1'b0,8'h5A},
    {1'b1,1'b1,1'b0,3'b000,1'b0,8'h00,1'b0,8'h5A},
    {1'b0,1'b0,1'b0,3'b000,1'b0,8'h2B,1'b1,8'h2B},
    {1'b1,1'b1,1'b0,3'b000,1'b0,8'h00,1'b1,8'h28},
    {1'b1,1'b0,1'b1,3'b100,1'b0,8'h77,1'b0,8'h28},
    {1'b0,1'b1,1'b1,3'b000,1'b1,8'h1D,1'b1,8'h1D},
    {1'b1,1'b1,1'b0,3'b000,1'b0,8'h00,1'b1,8'h1C},
    {1'b1,1'b1,1'b0,3'b000,1'b1,8'h00,1'b1,8'h1F}
  };
  localparam string TAG [NV] = '{
    "R2", "R8", "R8", "R8", "R10", "R11", "R6", "R9", "R9", "R9", "R10",
    "R4", "R5", "R3", "R7", "R2", "R9", "R5", "R2", "R8", "R8"
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic proc_strb_n = 1'b1, ctrl_strb_n = 1'b1, step_n = 1'b1, order_il = 1'b1;
  logic [2:0] en_n = 3'b111;
  logic [AW-1:0] ext_addr = '0;
  logic [AW-1:0] cur_addr, cur_addr_fx;
  logic busy, busy_fx;
  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_seq #(.AW(AW), .ORDER_FIXED(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .proc_strb_n(proc_strb_n), .ctrl_strb_n(ctrl_strb_n),
    .step_n(step_n), .en_n(en_n), .order_il(order_il), .ext_addr(ext_addr),
    .cur_addr(cur_addr), .busy(busy)
  );

  burst_addr_seq #(.AW(AW), .ORDER_FIXED(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .proc_strb_n(proc_strb_n), .ctrl_strb_n(ctrl_strb_n),
    .step_n(step_n), .en_n(en_n), .order_il(order_il), .ext_addr(ext_addr),
    .cur_addr(cur_addr_fx), .busy(busy_fx)
  );

  task automatic chk(input string tag, input logic [8:0] got, input logic [8:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got busy/addr %h, expected %h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    tick();
    tick();
    chk("R1", {busy, cur_addr}, {1'b0, 8'h00});
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      {proc_strb_n, ctrl_strb_n, step_n, en_n, order_il, ext_addr} = VEC[i][23:9];
      tick();
      chk(TAG[i], {busy, cur_addr}, VEC[i][8:0]);
      if (i == 16) chk("R12", {busy_fx, cur_addr_fx}, {1'b1, 8'h2A});
    end

    proc_strb_n = 1'b1; ctrl_strb_n = 1'b1; step_n = 1'b1; en_n = 3'b000;
    rst_n = 1'b0;
    tick();
    chk("R1", {busy, cur_addr}, {1'b0, 8'h00});
    rst_n = 1'b1;

    proc_strb_n = 1'b0; order_il = 1'b0; ext_addr = 8'hE7;
    tick();
    proc_strb_n = 1'b1; step_n = 1'b0;
    tick();
    chk("R9", {busy, cur_addr}, {1'b1, 8'hE4});
    chk("R12", {busy_fx, cur_addr_fx}, {1'b1, 8'hE6});
    tick();
    tick();
    tick();
    chk("R10", {busy, cur_addr}, {1'b1, 8'hE7});
    chk("R10", {busy_fx, cur_addr_fx}, {1'b1, 8'hE7});
    step_n = 1'b1;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule